// File: doc/BRIEF.md
# Cache line bypass-evict controller

This block keeps the coherence state of a handful of lines in a shared second-level cache, together with one transaction tracking entry per line. Each cycle it accepts at most one event: an invalidating probe, a memory response, a replacement notice or a core request. It answers with single-cycle strobes that tell the rest of the cache what to do: send a write-back, forward a read to memory, answer a probe, fill the line, pass the data straight through, report a hit, tell the requester to stall, or wake the requesters waiting on a line.

Reads may carry a bypass flag, meaning the data must not be kept in this cache. When such a read hits a dirty line, the controller writes the dirty data back and forwards the read in the same step. It then parks the line in a state that waits for the write-back acknowledge. The tracking entry stays alive and keeps the bypass flag across that acknowledge, so the read data that follows is still passed through and never filled. Every response is first classified by its type, and only a data response looks at the bypass flag.

The event that was accepted is reported through one grant strobe per source. All result strobes appear one clock after the grant, with the line index of that event on `evtLine`.

Top module: `bypass_line_ctrl`

## Requirements
- R1: After reset every result strobe and `errFlag` are low. Every line is Invalid with no live tracking entry, so a plain read to any line is forwarded.
- R2: A plain read (reqKind 0) to an Invalid line with no live entry forwards a read without the bypass flag and opens an entry. The data response (rspKind 0) then fills the line and wakes its waiters. A later plain read to that line gives only a hit.
- R3: A bypass read (reqKind 1) to a dirty line (after a victim write, reqKind 2, or a victim write-back, reqKind 3) gives a write-back, a forward and the bypass flag in the same cycle, and puts the line into the wait-then-bypass state.
- R4: A write-back acknowledge (rspKind 1) is classified before the bypass flag is checked. In the wait-then-bypass state it produces no strobe and keeps the entry. For an entry without the bypass flag it frees the entry and wakes the line.
- R5: A data response whose entry holds the bypass flag gives a pass-through, frees the entry and wakes the line, and never fills it. A data response for a line that is not waiting for a fill is also passed through.
- R6: Any request to a line in a transient state, or to a line with a live tracking entry, gives only a stall and changes nothing.
- R7: A replacement notice for a dirty line gives a write-back and waits for its acknowledge. For a transient line it only invalidates the tag: no strobe, and the pending response still completes.
- R8: A probe always gives a probe response. It leaves a transient line unchanged, invalidates a stable line, and also writes back a dirty one.
- R9: Grant priority is probe, then response, then replacement, then request. At most one grant is high in a cycle, and only the granted event has any effect.
- R10: A response of an unknown type (rspKind 2 or 3), or a response with no live entry, sets `errFlag`, which stays high until reset.
- R11: A bypass read to a clean or Invalid line forwards with the bypass flag and leaves the line Invalid. An atomic (reqKind 4) to a non-dirty line forwards, and its data is passed through, after which the line is Invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| prbValid | input | 1 | Invalidating probe present |
| prbLine | input | LineW | Probe line index |
| rspValid | input | 1 | Memory response present |
| rspLine | input | LineW | Response line index |
| rspKind | input | 2 | 0 data, 1 write-back ack, 2/3 unknown |
| rplValid | input | 1 | Replacement notice present |
| rplLine | input | LineW | Replaced line index |
| reqValid | input | 1 | Core request present |
| reqLine | input | LineW | Request line index |
| reqKind | input | 3 | 0 read, 1 bypass read, 2 victim write, 3 victim write-back, 4 atomic |
| prbTaken | output | 1 | Probe granted this cycle |
| rspTaken | output | 1 | Response granted this cycle |
| rplTaken | output | 1 | Replacement granted this cycle |
| reqTaken | output | 1 | Request granted this cycle |
| evtLine | output | LineW | Line index of last cycle's event |
| wbReq | output | 1 | Write-back of dirty data |
| fwdReq | output | 1 | Read forwarded to memory |
| fwdSlc | output | 1 | Forwarded read carries the bypass flag |
| prbAck | output | 1 | Invalidate probe response |
| bypassOut | output | 1 | Response data passed through uncached |
| fillOut | output | 1 | Response data written into the line |
| hitOut | output | 1 | Request served by the line |
| stallOut | output | 1 | Requester must wait for a wake |
| wakeOut | output | 1 | Waiters on evtLine may retry |
| errFlag | output | 1 | Sticky protocol error |

## Verification
The bench builds the block with the default of four lines. With that, every line can be brought to a different state during one vector walk: a dirty line in the wait-then-bypass state, a line waiting on a plain write-back, a pending atomic and a clean filled line. The walk covers the ack-before-flag classification, replacement and probe hits on transient lines, and stalls caused by an entry that outlives its state. Directed tests then press several sources in one cycle to show the grant order, and end with the sticky error.

// File: rtl/bypass_line_pkg.sv
package bypass_line_pkg;
  typedef enum logic [2:0] {
    ST_I   = 3'd0,
    ST_IV  = 3'd1,
    ST_WI  = 3'd2,
    ST_WIB = 3'd3,
    ST_A   = 3'd4,
    ST_V   = 3'd5,
    ST_W   = 3'd6,
    ST_M   = 3'd7
  } lineState_e;

  localparam logic [2:0] REQ_RD     = 3'd0;
  localparam logic [2:0] REQ_RDSLC  = 3'd1;
  localparam logic [2:0] REQ_WRVIC  = 3'd2;
  localparam logic [2:0] REQ_WRBACK = 3'd3;
  localparam logic [2:0] REQ_ATOMIC = 3'd4;

  localparam logic [1:0] RSP_DATA = 2'd0;
  localparam logic [1:0] RSP_ACK  = 2'd1;

  typedef struct packed {
    logic       setState;
    lineState_e newState;
    logic       allocTbe;
    logic       tbeSlc;
    logic       freeTbe;
    logic       wb;
    logic       fwd;
    logic       fwdSlc;
    logic       prb;
    logic       byp;
    logic       fill;
    logic       hit;
    logic       stall;
    logic       wake;
    logic       err;
  } strobes_t;
endpackage

// File: rtl/bypass_line_ctrl_fsm.sv
module bypass_line_ctrl_fsm
  import bypass_line_pkg::*;
#(
  parameter int LineW = 2
) (
  input  logic             prbValid,
  input  logic [LineW-1:0] prbLine,
  input  logic             rspValid,
  input  logic [LineW-1:0] rspLine,
  input  logic [1:0]       rspKind,
  input  logic             rplValid,
  input  logic [LineW-1:0] rplLine,
  input  logic             reqValid,
  input  logic [LineW-1:0] reqLine,
  input  logic [2:0]       reqKind,
  input  lineState_e       curState,
  input  logic             curTbeVld,
  input  logic             curTbeSlc,
  output logic [LineW-1:0] selLine,
  output logic             selValid,
  output logic             prbTaken,
  output logic             rspTaken,
  output logic             rplTaken,
  output logic             reqTaken,
  output strobes_t         stb
);
  logic isTransient;
  logic isDirty;

  always_comb begin
    prbTaken = prbValid;
    rspTaken = !prbValid && rspValid;
    rplTaken = !prbValid && !rspValid && rplValid;
    reqTaken = !prbValid && !rspValid && !rplValid && reqValid;
    selValid = prbValid || rspValid || rplValid || reqValid;
    if (prbTaken)      selLine = prbLine;
    else if (rspTaken) selLine = rspLine;
    else if (rplTaken) selLine = rplLine;
    else               selLine = reqLine;
  end

  assign isTransient = (curState == ST_IV) || (curState == ST_WI) ||
                       (curState == ST_WIB) || (curState == ST_A);
  assign isDirty = (curState == ST_W) || (curState == ST_M);

  always_comb begin
    stb = '0;
    stb.newState = ST_I;
    if (prbTaken) begin
      stb.prb = 1'b1;
      if (!isTransient) begin
        stb.wb       = isDirty;
        stb.setState = 1'b1;
        stb.newState = ST_I;
      end
    end else if (rspTaken) begin
      if (rspKind == RSP_ACK) begin
        if (!curTbeVld) begin
          stb.err = 1'b1;
        end else begin
          if (curState == ST_WI || curState == ST_WIB) begin
            stb.setState = 1'b1;
            stb.newState = ST_I;
          end
          if (!curTbeSlc) begin
            stb.freeTbe = 1'b1;
            stb.wake    = 1'b1;
          end
        end
      end else if (rspKind == RSP_DATA) begin
        if (!curTbeVld) begin
          stb.err = 1'b1;
        end else begin
          stb.freeTbe = 1'b1;
          stb.wake    = 1'b1;
          if (!curTbeSlc && curState == ST_IV) begin
            stb.fill     = 1'b1;
            stb.setState = 1'b1;
            stb.newState = ST_V;
          end else begin
            stb.byp = 1'b1;
            if (isTransient) begin
              stb.setState = 1'b1;
              stb.newState = ST_I;
            end
          end
        end
      end else begin
        stb.err = 1'b1;
      end
    end else if (rplTaken) begin
      if (isTransient || curState == ST_V) begin
        stb.setState = 1'b1;
        stb.newState = ST_I;
      end else if (isDirty) begin
        stb.wb       = 1'b1;
        stb.allocTbe = 1'b1;
        stb.setState = 1'b1;
        stb.newState = ST_WI;
      end
    end else if (reqTaken) begin
      if (isTransient || curTbeVld) begin
        stb.stall = 1'b1;
      end else begin
        unique case (reqKind)
          REQ_RD: begin
            if (curState == ST_I) begin
              stb.fwd      = 1'b1;
              stb.allocTbe = 1'b1;
              stb.setState = 1'b1;
              stb.newState = ST_IV;
            end else begin
              stb.hit = 1'b1;
            end
          end
          REQ_RDSLC: begin
            stb.fwd      = 1'b1;
            stb.fwdSlc   = 1'b1;
            stb.allocTbe = 1'b1;
            stb.tbeSlc   = 1'b1;
            stb.wb       = isDirty;
            stb.setState = 1'b1;
            stb.newState = isDirty ? ST_WIB : ST_I;
          end
          REQ_WRVIC: begin
            stb.setState = 1'b1;
            stb.newState = ST_W;
          end
          REQ_WRBACK: begin
            stb.setState = 1'b1;
            stb.newState = ST_M;
          end
          REQ_ATOMIC: begin
            if (isDirty) begin
              stb.hit = 1'b1;
            end else begin
              stb.fwd      = 1'b1;
              stb.allocTbe = 1'b1;
              stb.setState = 1'b1;
              stb.newState = ST_A;
            end
          end
          default: stb.err = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/bypass_line_datapath.sv
module bypass_line_datapath
  import bypass_line_pkg::*;
#(
  parameter int NumLines = 4,
  parameter int LineW    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LineW-1:0] selLine,
  input  logic             selValid,
  input  strobes_t         stb,
  output lineState_e       curState,
  output logic             curTbeVld,
  output logic             curTbeSlc,
  output logic [LineW-1:0] evtLine,
  output logic             wbReq,
  output logic             fwdReq,
  output logic             fwdSlc,
  output logic             prbAck,
  output logic             bypassOut,
  output logic             fillOut,
  output logic             hitOut,
  output logic             stallOut,
  output logic             wakeOut,
  output logic             errFlag
);
  lineState_e states [NumLines];
  logic [NumLines-1:0] tbeVld;
  logic [NumLines-1:0] tbeSlc;

  assign curState  = states[selLine];
  assign curTbeVld = tbeVld[selLine];
  assign curTbeSlc = tbeSlc[selLine];

  for (genvar g = 0; g < NumLines; g++) begin : gLine
    always_ff @(posedge clk) begin
      if (!rstN) begin
        states[g] <= ST_I;
        tbeVld[g] <= 1'b0;
        tbeSlc[g] <= 1'b0;
      end else if (selValid && selLine == LineW'(g)) begin
        if (stb.setState) states[g] <= stb.newState;
        if (stb.allocTbe) begin
          tbeVld[g] <= 1'b1;
          tbeSlc[g] <= stb.tbeSlc;
        end else if (stb.freeTbe) begin
          tbeVld[g] <= 1'b0;
          tbeSlc[g] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtLine   <= '0;
      wbReq     <= 1'b0;
      fwdReq    <= 1'b0;
      fwdSlc    <= 1'b0;
      prbAck    <= 1'b0;
      bypassOut <= 1'b0;
      fillOut   <= 1'b0;
      hitOut    <= 1'b0;
      stallOut  <= 1'b0;
      wakeOut   <= 1'b0;
      errFlag   <= 1'b0;
    end else begin
      evtLine   <= selLine;
      wbReq     <= stb.wb;
      fwdReq    <= stb.fwd;
      fwdSlc    <= stb.fwdSlc;
      prbAck    <= stb.prb;
      bypassOut <= stb.byp;
      fillOut   <= stb.fill;
      hitOut    <= stb.hit;
      stallOut  <= stb.stall;
      wakeOut   <= stb.wake;
      errFlag   <= errFlag | stb.err;
    end
  end
endmodule

// File: rtl/bypass_line_ctrl.sv
module bypass_line_ctrl
  import bypass_line_pkg::*;
#(
  parameter int NumLines = 4,
  localparam int LineW   = (NumLines > 1) ? $clog2(NumLines) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             prbValid,
  input  logic [LineW-1:0] prbLine,
  input  logic             rspValid,
  input  logic [LineW-1:0] rspLine,
  input  logic [1:0]       rspKind,
  input  logic             rplValid,
  input  logic [LineW-1:0] rplLine,
  input  logic             reqValid,
  input  logic [LineW-1:0] reqLine,
  input  logic [2:0]       reqKind,
  output logic             prbTaken,
  output logic             rspTaken,
  output logic             rplTaken,
  output logic             reqTaken,
  output logic [LineW-1:0] evtLine,
  output logic             wbReq,
  output logic             fwdReq,
  output logic             fwdSlc,
  output logic             prbAck,
  output logic             bypassOut,
  output logic             fillOut,
  output logic             hitOut,
  output logic             stallOut,
  output logic             wakeOut,
  output logic             errFlag
);
  strobes_t         stb;
  lineState_e       curState;
  logic             curTbeVld;
  logic             curTbeSlc;
  logic [LineW-1:0] selLine;
  logic             selValid;

  bypass_line_ctrl_fsm #(.LineW(LineW)) uFsm (
    .prbValid(prbValid), .prbLine(prbLine),
    .rspValid(rspValid), .rspLine(rspLine), .rspKind(rspKind),
    .rplValid(rplValid), .rplLine(rplLine),
    .reqValid(reqValid), .reqLine(reqLine), .reqKind(reqKind),
    .curState(curState), .curTbeVld(curTbeVld), .curTbeSlc(curTbeSlc),
    .selLine(selLine), .selValid(selValid),
    .prbTaken(prbTaken), .rspTaken(rspTaken),
    .rplTaken(rplTaken), .reqTaken(reqTaken),
    .stb(stb)
  );

  bypass_line_datapath #(.NumLines(NumLines), .LineW(LineW)) uDp (
    .clk(clk), .rstN(rstN),
    .selLine(selLine), .selValid(selValid), .stb(stb),
    .curState(curState), .curTbeVld(curTbeVld), .curTbeSlc(curTbeSlc),
    .evtLine(evtLine), .wbReq(wbReq), .fwdReq(fwdReq), .fwdSlc(fwdSlc),
    .prbAck(prbAck), .bypassOut(bypassOut), .fillOut(fillOut),
    .hitOut(hitOut), .stallOut(stallOut), .wakeOut(wakeOut),
    .errFlag(errFlag)
  );
endmodule

// File: rtl/bypass_line_ctrl_chk.sv
module bypass_line_ctrl_chk (
  input logic clk,
  input logic rstN,
  input logic prbValid,
  input logic rspValid,
  input logic prbTaken,
  input logic rspTaken,
  input logic rplTaken,
  input logic reqTaken,
  input logic wbReq,
  input logic fwdReq,
  input logic fwdSlc,
  input logic bypassOut,
  input logic fillOut,
  input logic hitOut,
  input logic stallOut,
  input logic errFlag
);
  // R9
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({prbTaken, rspTaken, rplTaken, reqTaken}));

  // R9
  probe_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    prbValid |-> prbTaken && !rspTaken);

  // R9
  rsp_before_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!prbValid && rspValid) |-> rspTaken && !reqTaken);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  // R5
  no_fill_on_bypass_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(bypassOut && fillOut));

  // R6
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    stallOut |-> !wbReq && !fwdReq && !hitOut);

  // R3
  slc_with_fwd_chk: assert property (@(posedge clk) disable iff (!rstN)
    fwdSlc |-> fwdReq);
endmodule

bind bypass_line_ctrl bypass_line_ctrl_chk uChk (
  .clk(clk), .rstN(rstN), .prbValid(prbValid), .rspValid(rspValid),
  .prbTaken(prbTaken), .rspTaken(rspTaken), .rplTaken(rplTaken),
  .reqTaken(reqTaken), .wbReq(wbReq), .fwdReq(fwdReq), .fwdSlc(fwdSlc),
  .bypassOut(bypassOut), .fillOut(fillOut), .hitOut(hitOut),
  .stallOut(stallOut), .errFlag(errFlag)
);

// File: tb/tb_bypass_line_ctrl.sv
module tb_bypass_line_ctrl;
  localparam int NumLines = 4;
  localparam int LineW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic prbValid = 0, rspValid = 0, rplValid = 0, reqValid = 0;
  logic [LineW-1:0] prbLine = 0, rspLine = 0, rplLine = 0, reqLine = 0;
  logic [1:0] rspKind = 0;
  logic [2:0] reqKind = 0;
  logic prbTaken, rspTaken, rplTaken, reqTaken;
  logic [LineW-1:0] evtLine;
  logic wbReq, fwdReq, fwdSlc, prbAck, bypassOut, fillOut, hitOut;
  logic stallOut, wakeOut, errFlag;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bypass_line_ctrl #(.NumLines(NumLines)) dut (.*);

  // result bits: wb fwd fwdSlc prb byp fill hit stall wake err
  function automatic logic [9:0] outs();
    return {wbReq, fwdReq, fwdSlc, prbAck, bypassOut, fillOut, hitOut,
            stallOut, wakeOut, errFlag};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clearIn();
    prbValid = 0; rspValid = 0; rplValid = 0; reqValid = 0;
  endtask

  // source: 0 request, 1 response, 2 replacement, 3 probe
  task automatic drive(input logic [1:0] src, input logic [1:0] ln, input logic [2:0] kind);
    clearIn();
    case (src)
      2'd0: begin reqValid = 1; reqLine = ln; reqKind = kind; end
      2'd1: begin rspValid = 1; rspLine = ln; rspKind = kind[1:0]; end
      2'd2: begin rplValid = 1; rplLine = ln; end
      default: begin prbValid = 1; prbLine = ln; end
    endcase
  endtask

  localparam int NVec = 32;
  // {src[1:0], line[1:0], kind[2:0], exp[9:0], tag[3:0]}
  localparam logic [20:0] VECS [NVec] = '{
    {2'd0, 2'd0, 3'd0, 10'h100, 4'd2},
    {2'd1, 2'd0, 3'd0, 10'h012, 4'd2},
    {2'd0, 2'd0, 3'd0, 10'h008, 4'd2},
    {2'd0, 2'd1, 3'd2, 10'h000, 4'd3},
    {2'd0, 2'd1, 3'd1, 10'h380, 4'd3},
    {2'd0, 2'd1, 3'd0, 10'h004, 4'd6},
    {2'd0, 2'd1, 3'd1, 10'h004, 4'd6},
    {2'd0, 2'd1, 3'd4, 10'h004, 4'd6},
    {2'd1, 2'd1, 3'd1, 10'h000, 4'd4},
    {2'd0, 2'd1, 3'd2, 10'h004, 4'd6},
    {2'd1, 2'd1, 3'd0, 10'h022, 4'd5},
    {2'd0, 2'd1, 3'd0, 10'h100, 4'd5},
    {2'd1, 2'd1, 3'd0, 10'h012, 4'd2},
    {2'd0, 2'd2, 3'd3, 10'h000, 4'd7},
    {2'd2, 2'd2, 3'd0, 10'h200, 4'd7},
    {2'd0, 2'd2, 3'd0, 10'h004, 4'd6},
    {2'd1, 2'd2, 3'd1, 10'h002, 4'd4},
    {2'd0, 2'd2, 3'd0, 10'h100, 4'd4},
    {2'd3, 2'd2, 3'd0, 10'h040, 4'd8},
    {2'd1, 2'd2, 3'd0, 10'h012, 4'd8},
    {2'd3, 2'd2, 3'd0, 10'h040, 4'd8},
    {2'd0, 2'd2, 3'd0, 10'h100, 4'd8},
    {2'd1, 2'd2, 3'd0, 10'h012, 4'd2},
    {2'd0, 2'd3, 3'd4, 10'h100, 4'd11},
    {2'd2, 2'd3, 3'd0, 10'h000, 4'd7},
    {2'd1, 2'd3, 3'd0, 10'h022, 4'd7},
    {2'd0, 2'd3, 3'd2, 10'h000, 4'd3},
    {2'd3, 2'd3, 3'd0, 10'h240, 4'd8},
    {2'd0, 2'd0, 3'd1, 10'h180, 4'd11},
    {2'd1, 2'd0, 3'd0, 10'h022, 4'd5},
    {2'd0, 2'd3, 3'd1, 10'h180, 4'd11},
    {2'd1, 2'd3, 3'd0, 10'h022, 4'd5}
  };

  function automatic string tagName(input logic [3:0] t);
    case (t)
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R11";
    endcase
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: quiet outputs after reset
    check("R1", {22'd0, outs()}, 32'h0);
    for (int i = 0; i < NVec; i++) begin
      drive(VECS[i][20:19], VECS[i][18:17], VECS[i][16:14]);
      @(negedge clk);
      clearIn();
      check(tagName(VECS[i][3:0]), {22'd0, outs()}, {22'd0, VECS[i][13:4]});
      check(tagName(VECS[i][3:0]), {30'd0, evtLine}, {30'd0, VECS[i][18:17]});
    end

    // R9: probe, response and request together; only the probe acts
    // line1 is V here, line0 is I with no entry
    prbValid = 1; prbLine = 2'd1;
    rspValid = 1; rspLine = 2'd0; rspKind = 2'd3;
    reqValid = 1; reqLine = 2'd0; reqKind = 3'd0;
    #1;
    check("R9", {28'd0, prbTaken, rspTaken, rplTaken, reqTaken}, 32'h8);
    @(negedge clk);
    check("R9", {22'd0, outs()}, 32'h040);
    // replacement beats request
    prbValid = 0; rspValid = 0;
    rplValid = 1; rplLine = 2'd2;
    #1;
    check("R9", {28'd0, prbTaken, rspTaken, rplTaken, reqTaken}, 32'h2);
    @(negedge clk);
    clearIn();
    // line2 was V: replacement invalidates quietly; no request acted
    check("R9", {22'd0, outs()}, 32'h0);
    // R1: line2 now Invalid, plain read forwards
    drive(2'd0, 2'd2, 3'd0);
    @(negedge clk);
    clearIn();
    check("R1", {22'd0, outs()}, 32'h100);

    // R10: unknown response type sets the error flag
    drive(2'd1, 2'd0, 3'd2);
    @(negedge clk);
    clearIn();
    check("R10", {31'd0, errFlag}, 32'h1);
    @(negedge clk);
    check("R10", {31'd0, errFlag}, 32'h1);
    // R10: ack with no entry keeps flag, no wake
    drive(2'd1, 2'd1, 3'd1);
    @(negedge clk);
    clearIn();
    check("R10", {22'd0, outs()}, 32'h001);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule